// File: doc/BRIEF.md
# Adaptive Hop Channel Remapper

This block sits between a basic hop-sequence generator and the radio of a frequency-hopping link on the 79-channel 2.4 GHz band, where channel n lies at 2402+n MHz. It keeps one bit per channel, 1 for used and 0 for unused, and turns each channel index picked by the base sequence into the channel actually transmitted on. A picked channel that is still used passes through unchanged. A picked channel that is unused is replaced by an entry from the ascending list of used channels, so interfered channels never appear on air.

Channels are marked unused from measured error statistics. Each packet report carries a channel and an error flag. Per channel, the block counts packets and errors over a fixed window and drops the channel once its error count in the window exceeds a programmable threshold. Firmware may also force channels in or out through a write port, and can read the map back. A dropped channel comes back on its own after a programmable number of slots. The map never shrinks below a floor of used channels. Edits go into a pending map. The map used for remapping copies the pending map only at a slot boundary, so both ends of the link switch together.

The hop stream is valid/ready. A hop is accepted when `hop_valid` and `hop_ready` are both high. `hop_ready` is high whenever the output register is empty or is being drained in the same cycle. A result is held stable in `out_chan` until `out_ready` takes it. Error reports are also valid/ready and are held off while a firmware write is presented.

Top module: `afh_hop_remapper`

## Requirements
- R1: After reset the pending and active maps mark every channel used, `out_valid` is 0 and `hop_ready` is 1.
- R2: A hop accepted on a channel whose active bit is 1 yields `out_valid`=1 with `out_chan` equal to that channel in the next cycle.
- R3: A hop accepted on a channel whose active bit is 0 yields, in the next cycle, the used channel of rank k in ascending channel order (rank 0 is the lowest used channel), where k = picked channel mod number of used channels.
- R4: `hop_ready` = !`out_valid` || `out_ready`; while `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_chan` hold their values.
- R5: Each accepted report adds 1 to the packet count and `rpt_err` to the error count of its channel. When the new error count exceeds `err_thresh`, that channel's pending bit is cleared at that clock edge and both of its counts return to 0. Reports naming a channel at or above the channel count have no effect.
- R6: When a report brings a channel's packet count to WINDOW without crossing the threshold, both of its counts return to 0, so errors from an earlier window are forgotten.
- R7: A clear from either source on a used channel is refused when the pending map holds exactly MIN_USED used channels; the pending map never holds fewer.
- R8: A write with `ovr_valid`=1 sets the pending bit of `ovr_chan` to `ovr_used` at the next edge, subject to R7. A write naming a channel at or above the channel count is ignored. `rpt_ready` is 0 while `ovr_valid` is 1.
- R9: The active map copies the pending map at each edge where `slot_tick` is 1 and is unchanged otherwise. Hops are always remapped with the active map.
- R10: An unused pending channel counts slot ticks. At the tick that brings its count to `age_limit`, it is set used again and its count restarts. A clear of the channel restarts its count at 0.
- R11: `map_rd` shows the pending map, with bit n for channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hop_valid | input | 1 | Picked channel is presented |
| hop_ready | output | 1 | Block accepts a picked channel |
| hop_chan | input | CH_W | Channel from the base sequence |
| out_valid | output | 1 | Final channel is presented |
| out_ready | input | 1 | Consumer takes the final channel |
| out_chan | output | CH_W | Final channel |
| rpt_valid | input | 1 | Packet report is presented |
| rpt_ready | output | 1 | Block accepts a report |
| rpt_chan | input | CH_W | Channel the packet used |
| rpt_err | input | 1 | Packet was received in error |
| ovr_valid | input | 1 | Firmware map write |
| ovr_chan | input | CH_W | Channel to write |
| ovr_used | input | 1 | Value written: 1 used, 0 unused |
| slot_tick | input | 1 | Slot boundary strobe |
| err_thresh | input | ERR_W | Error count that must be exceeded |
| age_limit | input | AGE_W | Slots before a dropped channel returns |
| map_rd | output | NUM_CH | Pending channel map |

## Verification
The assertions take for granted that `hop_chan` is always below the channel count when `hop_valid` is high, that MIN_USED does not exceed the channel count, and that `age_limit` is at least 1. The bench drives only in-range picked channels and sets `age_limit` to 15 and then 3. Map edits and slot ticks are never driven in the same cycle, so the order in which aging and a clear act on one channel is not exercised. Out-of-range channel numbers are sent only on the report and write ports, where they are meant to be ignored.

// File: rtl/afh_pkg.sv
package afh_pkg;

  // Map edit presented to the pending-map keeper in one cycle
  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_SET  = 2'd1,
    UPD_CLR  = 2'd2
  } upd_op_e;

endpackage

// File: rtl/afh_err_stats.sv
module afh_err_stats #(
  parameter int NUM_CH = 79,
  parameter int WINDOW = 16,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int ERR_W  = $clog2(WINDOW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rpt_fire,
  input  logic [CH_W-1:0]  rpt_chan,
  input  logic             rpt_err,
  input  logic [ERR_W-1:0] err_thresh,
  output logic             drop_req
);

  logic [NUM_CH-1:0] trip_vec;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [ERR_W-1:0] pkt_q, err_q, pkt_nx, err_nx;
    logic             hit;

    assign hit    = rpt_fire && (rpt_chan == CH_W'(g));
    assign pkt_nx = pkt_q + ERR_W'(1);
    assign err_nx = err_q + ERR_W'(rpt_err);
    assign trip_vec[g] = hit && (err_nx > err_thresh);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pkt_q <= '0;
        err_q <= '0;
      end else if (hit) begin
        if (trip_vec[g] || pkt_nx == ERR_W'(WINDOW)) begin
          pkt_q <= '0;
          err_q <= '0;
        end else begin
          pkt_q <= pkt_nx;
          err_q <= err_nx;
        end
      end
    end

    // R6: a window never closes with more errors than packets, nor overruns
    a_r6_err_within_pkts: assert property (@(posedge clk) disable iff (!rst_n)
      err_q <= pkt_q);
    a_r6_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_q < ERR_W'(WINDOW));
    // R5: a trip restarts that channel's counts
    a_r5_trip_restart: assert property (@(posedge clk) disable iff (!rst_n)
      trip_vec[g] |=> (pkt_q == '0 && err_q == '0));
  end

  assign drop_req = |trip_vec;

endmodule

// File: rtl/afh_map_keeper.sv
module afh_map_keeper
  import afh_pkg::*;
#(
  parameter int NUM_CH   = 79,
  parameter int MIN_USED = 20,
  parameter int AGE_W    = 8,
  parameter int CH_W     = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  upd_op_e           upd_op,
  input  logic [CH_W-1:0]   upd_chan,
  input  logic              slot_tick,
  input  logic [AGE_W-1:0]  age_limit,
  output logic [NUM_CH-1:0] pend_map,
  output logic [NUM_CH-1:0] act_map
);

  localparam int CNT_W = $clog2(NUM_CH + 1);

  logic [NUM_CH-1:0] pend_q, act_q, sel_vec;
  logic [CNT_W-1:0]  used_cnt;
  logic              tgt_used, clr_ok;

  always_comb begin
    used_cnt = '0;
    tgt_used = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      sel_vec[i] = (upd_chan == CH_W'(i));
      used_cnt   = used_cnt + CNT_W'(pend_q[i]);
      if (sel_vec[i]) tgt_used = pend_q[i];
    end
    clr_ok = (upd_op == UPD_CLR) && (!tgt_used || used_cnt > CNT_W'(MIN_USED));
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [AGE_W-1:0] age_q;
    logic             back, hit_clr, nxt;

    assign back    = slot_tick && !pend_q[g] &&
                     ({1'b0, age_q} + (AGE_W+1)'(1) >= {1'b0, age_limit});
    assign hit_clr = sel_vec[g] && clr_ok;

    always_comb begin
      nxt = pend_q[g] | back | (sel_vec[g] && upd_op == UPD_SET);
      if (hit_clr) nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b1;
        age_q     <= '0;
      end else begin
        pend_q[g] <= nxt;
        if (nxt || hit_clr) age_q <= '0;
        else if (slot_tick)  age_q <= age_q + AGE_W'(1);
      end
    end

    // R10: an unused channel at its age limit is back after the tick
    a_r10_age_return: assert property (@(posedge clk) disable iff (!rst_n)
      (back && !hit_clr) |=> pend_q[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         act_q <= '1;
    else if (slot_tick) act_q <= pend_q;
  end

  assign pend_map = pend_q;
  assign act_map  = act_q;

  // R7: the pending map never drops below the floor
  a_r7_floor: assert property (@(posedge clk) disable iff (!rst_n)
    used_cnt >= CNT_W'(MIN_USED));
  // R9: the active map moves only at a slot boundary, and then to the pending map
  a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> $stable(act_q));
  a_r9_copy_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |=> act_q == $past(pend_q));

endmodule

// File: rtl/afh_chan_select.sv
module afh_chan_select #(
  parameter int NUM_CH = 79,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] act_map,
  input  logic              hop_valid,
  input  logic [CH_W-1:0]   hop_chan,
  output logic              hop_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CH_W-1:0]   out_chan
);

  localparam int CNT_W = $clog2(NUM_CH + 1);
  localparam int SEL_W = (CH_W > CNT_W) ? CH_W : CNT_W;

  logic [CNT_W-1:0] n_used, acc;
  logic [SEL_W-1:0] rank_want;
  logic [CH_W-1:0]  alt_chan, res_chan;
  logic             pick_used, hop_fire;

  always_comb begin
    n_used    = '0;
    pick_used = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      n_used = n_used + CNT_W'(act_map[i]);
      if (hop_chan == CH_W'(i)) pick_used = act_map[i];
    end
    rank_want = (n_used == '0) ? '0 : SEL_W'(hop_chan) % SEL_W'(n_used);
    acc       = '0;
    alt_chan  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (act_map[i]) begin
        if (SEL_W'(acc) == rank_want) alt_chan = CH_W'(i);
        acc = acc + CNT_W'(1);
      end
    end
    res_chan = pick_used ? hop_chan : alt_chan;
  end

  assign hop_ready = !out_valid || out_ready;
  assign hop_fire  = hop_valid && hop_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
    end else if (hop_fire) begin
      out_valid <= 1'b1;
      out_chan  <= res_chan;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // Input assumption: picked channels are always inside the band
  a_r3_pick_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    hop_valid |-> ({1'b0, hop_chan} < (CH_W+1)'(NUM_CH)));
  // R2: a used pick comes out unchanged one cycle later
  a_r2_pass_used: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_fire && pick_used) |=> (out_valid && out_chan == $past(hop_chan)));
  // R3: every accepted pick produces a result next cycle
  a_r3_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    hop_fire |=> out_valid);
  // R4: a stalled result is held
  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_chan)));

endmodule

// File: rtl/afh_hop_remapper.sv
module afh_hop_remapper
  import afh_pkg::*;
#(
  parameter int NUM_CH   = 79,
  parameter int MIN_USED = 20,
  parameter int WINDOW   = 16,
  parameter int AGE_W    = 8,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int ERR_W   = $clog2(WINDOW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hop_valid,
  output logic              hop_ready,
  input  logic [CH_W-1:0]   hop_chan,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CH_W-1:0]   out_chan,
  input  logic              rpt_valid,
  output logic              rpt_ready,
  input  logic [CH_W-1:0]   rpt_chan,
  input  logic              rpt_err,
  input  logic              ovr_valid,
  input  logic [CH_W-1:0]   ovr_chan,
  input  logic              ovr_used,
  input  logic              slot_tick,
  input  logic [ERR_W-1:0]  err_thresh,
  input  logic [AGE_W-1:0]  age_limit,
  output logic [NUM_CH-1:0] map_rd
);

  logic              rpt_fire, ovr_fire, drop_req;
  upd_op_e           upd_op;
  logic [CH_W-1:0]   upd_chan;
  logic [NUM_CH-1:0] act_map;

  assign rpt_ready = !ovr_valid;
  assign rpt_fire  = rpt_valid && rpt_ready;
  assign ovr_fire  = ovr_valid && ({1'b0, ovr_chan} < (CH_W+1)'(NUM_CH));

  always_comb begin
    upd_chan = ovr_valid ? ovr_chan : rpt_chan;
    if (ovr_fire)      upd_op = ovr_used ? UPD_SET : UPD_CLR;
    else if (drop_req) upd_op = UPD_CLR;
    else               upd_op = UPD_NONE;
  end

  afh_err_stats #(.NUM_CH(NUM_CH), .WINDOW(WINDOW), .CH_W(CH_W), .ERR_W(ERR_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .rpt_fire(rpt_fire), .rpt_chan(rpt_chan),
    .rpt_err(rpt_err), .err_thresh(err_thresh), .drop_req(drop_req)
  );

  afh_map_keeper #(.NUM_CH(NUM_CH), .MIN_USED(MIN_USED), .AGE_W(AGE_W), .CH_W(CH_W)) u_map (
    .clk(clk), .rst_n(rst_n), .upd_op(upd_op), .upd_chan(upd_chan),
    .slot_tick(slot_tick), .age_limit(age_limit), .pend_map(map_rd), .act_map(act_map)
  );

  afh_chan_select #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .act_map(act_map), .hop_valid(hop_valid),
    .hop_chan(hop_chan), .hop_ready(hop_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_chan(out_chan)
  );

  // R8: reports are held off while a firmware write is presented
  a_r8_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_valid |-> !rpt_fire);
  // R8: an out-of-band write leaves the pending map alone
  a_r8_bad_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid && !ovr_fire && !slot_tick) |=> $stable(map_rd));

endmodule

// File: tb/afh_hop_remapper_tb_top.sv
module afh_hop_remapper_tb_top;

  localparam int NUM_CH = 13;
  localparam int MINU   = 4;
  localparam int WIN    = 8;
  localparam int AGE_W  = 4;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int ERR_W  = $clog2(WIN + 1);

  logic clk = 0, rst_n = 0;
  logic hop_valid = 0, hop_ready, out_valid, out_ready = 1;
  logic [CH_W-1:0] hop_chan = '0, out_chan, rpt_chan = '0, ovr_chan = '0;
  logic rpt_valid = 0, rpt_ready, rpt_err = 0, ovr_valid = 0, ovr_used = 0, slot_tick = 0;
  logic [ERR_W-1:0] err_thresh = ERR_W'(2);
  logic [AGE_W-1:0] age_limit = AGE_W'(15);
  logic [NUM_CH-1:0] map_rd;

  int checks = 0, failures = 0;

  // bench model
  bit [NUM_CH-1:0] m_pend = '1, m_act = '1;
  int m_age [NUM_CH];
  int m_pkt [NUM_CH];
  int m_err [NUM_CH];
  int m_lim = 15;

  always #5 clk = ~clk;

  afh_hop_remapper #(.NUM_CH(NUM_CH), .MIN_USED(MINU), .WINDOW(WIN), .AGE_W(AGE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .hop_valid(hop_valid), .hop_ready(hop_ready),
    .hop_chan(hop_chan), .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
    .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_chan(rpt_chan), .rpt_err(rpt_err),
    .ovr_valid(ovr_valid), .ovr_chan(ovr_chan), .ovr_used(ovr_used), .slot_tick(slot_tick),
    .err_thresh(err_thresh), .age_limit(age_limit), .map_rd(map_rd)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pop(input bit [NUM_CH-1:0] m);
    int n = 0;
    for (int i = 0; i < NUM_CH; i++) n += m[i];
    return n;
  endfunction

  function automatic int expect_chan(input int s);
    int n = pop(m_act), k, r = 0;
    if (m_act[s]) return s;
    k = s % n;
    for (int i = 0; i < NUM_CH; i++)
      if (m_act[i]) begin
        if (r == k) return i;
        r++;
      end
    return -1;
  endfunction

  function automatic void model_clear(input int c);
    if (m_pend[c] && pop(m_pend) <= MINU) return;  // refused floor
    m_pend[c] = 0;
    m_age[c]  = 0;
  endfunction

  task automatic check_map(input string req);
    chk(map_rd == m_pend, req, map_rd, m_pend);
  endtask

  task automatic do_hop(input int s, input string req);
    int e = expect_chan(s);
    hop_valid = 1; hop_chan = CH_W'(s); out_ready = 1;
    @(negedge clk);
    chk(out_valid && out_chan == CH_W'(e), req, out_chan, e);
    hop_valid = 0;
  endtask

  task automatic sweep(input string req);
    for (int s = 0; s < NUM_CH; s++) do_hop(s, req);
    @(negedge clk);
  endtask

  task automatic do_ovr(input int c, input bit u);
    ovr_valid = 1; ovr_chan = CH_W'(c); ovr_used = u;
    @(negedge clk);
    ovr_valid = 0;
    if (c < NUM_CH) begin
      if (u) m_pend[c] = 1;
      else   model_clear(c);
      if (m_pend[c]) m_age[c] = 0;
    end
  endtask

  task automatic do_rpt(input int c, input bit e);
    rpt_valid = 1; rpt_chan = CH_W'(c); rpt_err = e;
    @(negedge clk);
    rpt_valid = 0;
    if (c < NUM_CH) begin
      int ne = m_err[c] + e, np = m_pkt[c] + 1;
      if (ne > int'(err_thresh)) begin
        model_clear(c); m_err[c] = 0; m_pkt[c] = 0;
      end else if (np == WIN) begin
        m_err[c] = 0; m_pkt[c] = 0;
      end else begin
        m_err[c] = ne; m_pkt[c] = np;
      end
    end
  endtask

  task automatic do_tick();
    slot_tick = 1;
    @(negedge clk);
    slot_tick = 0;
    m_act = m_pend;
    for (int c = 0; c < NUM_CH; c++)
      if (!m_pend[c]) begin
        if (m_age[c] + 1 >= m_lim) begin m_pend[c] = 1; m_age[c] = 0; end
        else m_age[c]++;
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < NUM_CH; c++) begin m_age[c] = 0; m_pkt[c] = 0; m_err[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R11: reset state
    check_map("R1 R11 reset map");
    chk(!out_valid, "R1 out_valid", out_valid, 0);
    chk(hop_ready, "R1 hop_ready", hop_ready, 1);

    sweep("R2 identity full map");

    for (int c = 5; c <= 10; c++) do_ovr(c, 0);
    check_map("R8 R11 firmware clears");
    sweep("R9 pending not yet active");
    do_tick();
    sweep("R3 remap after first slot");

    for (int c = 0; c <= 2; c++) do_ovr(c, 0);
    check_map("R8 clear down to floor");
    do_ovr(11, 0);
    check_map("R7 clear below floor refused");
    chk(map_rd[11], "R7 channel 11 kept", map_rd[11], 1);
    do_tick();
    sweep("R3 remap at floor");

    for (int c = 0; c < NUM_CH; c++) do_ovr(c, 1);
    check_map("R8 restore all");
    do_tick();
    sweep("R2 identity after restore");

    do_ovr(14, 0);
    check_map("R8 out-of-band write ignored");
    do_rpt(13, 1); do_rpt(13, 1); do_rpt(13, 1);
    check_map("R5 out-of-band report ignored");

    // R8: reports held off while a write is presented
    ovr_valid = 1; ovr_chan = CH_W'(15); ovr_used = 0; rpt_valid = 1; rpt_chan = CH_W'(6); rpt_err = 1;
    #1;
    chk(!rpt_ready, "R8 rpt_ready low during write", rpt_ready, 0);
    @(negedge clk);
    ovr_valid = 0; rpt_valid = 0;

    // R5: errors exceed threshold 2 on third error
    do_rpt(3, 1); check_map("R5 one error");
    do_rpt(3, 1); check_map("R5 two errors");
    do_rpt(3, 1); check_map("R5 third error drops");
    chk(!map_rd[3], "R5 channel 3 dropped", map_rd[3], 0);

    // R6: window closes after WIN packets
    do_rpt(4, 1); do_rpt(4, 1);
    for (int i = 0; i < 6; i++) do_rpt(4, 0);
    do_rpt(4, 1); do_rpt(4, 1);
    check_map("R6 old errors forgotten");
    chk(map_rd[4], "R6 channel 4 kept", map_rd[4], 1);
    do_rpt(4, 1);
    check_map("R6 R5 new window drops");
    chk(!map_rd[4], "R5 channel 4 dropped", map_rd[4], 0);

    // R10: aging with limit 3
    age_limit = AGE_W'(3); m_lim = 3;
    do_tick(); check_map("R10 age tick 1");
    do_tick(); check_map("R10 age tick 2");
    chk(!map_rd[3], "R10 not back yet", map_rd[3], 0);
    do_tick(); check_map("R10 age tick 3");
    chk(map_rd[3] && map_rd[4], "R10 channels back", map_rd[4:3], 3);

    // another map shape for the remap sweep
    do_ovr(0, 0); do_ovr(6, 0); do_ovr(12, 0);
    do_tick();
    sweep("R3 R9 remap sparse map");

    // R4: back-pressure
    out_ready = 0; hop_valid = 1; hop_chan = CH_W'(6);
    @(negedge clk);
    chk(out_valid && out_chan == CH_W'(expect_chan(6)), "R4 first result", out_chan, expect_chan(6));
    hop_chan = CH_W'(2);
    chk(!hop_ready, "R4 hop_ready low when stalled", hop_ready, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid && out_chan == CH_W'(expect_chan(6)), "R4 result held", out_chan, expect_chan(6));
    end
    out_ready = 1;
    #1;
    chk(hop_ready, "R4 hop_ready with out_ready", hop_ready, 1);
    @(negedge clk);
    chk(out_valid && out_chan == CH_W'(expect_chan(2)), "R4 next result", out_chan, expect_chan(2));
    hop_valid = 0;
    @(negedge clk);
    chk(!out_valid, "R4 drained", out_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule